// File: doc/BRIEF.md
# Human Reaction Timer

This block measures how quickly a person responds to a light. It runs from a 1 kHz clock, so each clock cycle is one millisecond. When synchronous reset is released, a fixed pre-light delay of 10000 cycles (ten seconds) starts. At the end of that delay the light enable goes high and a millisecond count begins. The count stops on the first clock edge at which the button input is sampled high, and that count appears in binary on the result output.

If the person has not responded after 2000 milliseconds, the attempt is marked slow. In that case the result output shows the limit value 2000. In both outcomes the light goes off at the edge that captures the result. The result and the slow flag then hold until the next reset.

All timing comes from one internal cycle counter that the phase controller clears and enables. No timer component is instantiated.

Top module: `reaction_timer`

## Requirements
- R1: While `rst` is sampled high on a rising edge, `light_en`, `too_slow` and `react_ms` all become 0 at that edge. The phase returns to the pre-light delay.
- R2: `light_en` rises at exactly the WAIT_CYCLES-th (10000th) rising edge that samples `rst` low. It is 0 at every earlier edge.
- R3: If `button` is first sampled high at the n-th rising edge after the one that raised `light_en` (1 <= n <= 2000), then at that edge `react_ms` becomes n and `too_slow` stays 0.
- R4: `light_en` returns to 0 at the same edge that captures a result, whether the capture comes from a press or from the timeout.
- R5: If `button` is sampled low on all 2000 edges after the light comes on, then at the 2000th edge `too_slow` becomes 1 and `react_ms` becomes 2000 (LIMIT_MS).
- R6: If a press is sampled on the 2000th edge itself, it counts as a press: `react_ms` is 2000 and `too_slow` stays 0.
- R7: `button` held high during the pre-light delay has no effect. The light still rises at the 10000th edge, and `react_ms` and `too_slow` stay 0.
- R8: Once a result is captured, `react_ms` and `too_slow` hold their values and `light_en` stays 0, whatever `button` does, until the next reset.
- R9: `react_ms` is a 12-bit unsigned binary count. It and `too_slow` stay 0 while the light is on and before any capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1 kHz clock, one cycle per millisecond |
| rst | input | 1 | Synchronous reset, active high |
| button | input | 1 | Response button, high means pressed (sampled level) |
| light_en | output | 1 | Light enable, high during the measuring phase |
| react_ms | output | 12 | Measured reaction time in milliseconds |
| too_slow | output | 1 | Set when no press arrived within the limit |

## Verification
The bench goes after the edges of every window, and each one catches a specific fault.
- It checks the light one edge before and at the 10000th edge. A design with an off-by-one delay would light early or late.
- It checks presses at the first edge and at the 2000th edge. A counter that starts at the wrong value, or a timeout that wins over a simultaneous press, would report a wrong time or a false slow flag.
- It holds the button through the whole delay. A design that does not ignore presses in that phase would capture a result before the light appears.
- It toggles the button after each capture. A design whose result registers are not held would lose or overwrite the reported time.

// File: rtl/reaction_timer_pkg.sv
package reaction_timer_pkg;

    typedef enum logic [1:0] {
        PH_DELAY = 2'd0,
        PH_TIMING = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

endpackage

// File: rtl/rt_cycle_counter.sv
module rt_cycle_counter #(
    parameter int WIDTH = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    output logic [WIDTH-1:0] count
);

    logic [WIDTH-1:0] cnt_d;
    logic [WIDTH-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = cnt_q + WIDTH'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

    // R2: a clear request always leaves the count at zero on the next edge
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

    // R8: without enable or clear the count must not move
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!clr && !en) |=> $stable(cnt_q));

endmodule

// File: rtl/rt_phase_ctrl.sv
module rt_phase_ctrl
    import reaction_timer_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int TIME_W = 12,
    parameter int WAIT_CYCLES = 10000,
    parameter int LIMIT_MS = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              button,
    input  logic [CNT_W-1:0]  cnt,
    output logic              cnt_clr,
    output logic              cnt_en,
    output logic              light,
    output logic              slow,
    output logic [TIME_W-1:0] rtime
);

    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYCLES - 1);
    localparam logic [CNT_W-1:0] LIMIT_CNT = CNT_W'(LIMIT_MS);
    localparam logic [TIME_W-1:0] LIMIT_VAL = TIME_W'(LIMIT_MS);

    typedef struct packed {
        phase_e            phase;
        logic              light;
        logic              slow;
        logic [TIME_W-1:0] rtime;
    } ctrl_t;

    ctrl_t st_d;
    ctrl_t st_q;
    logic [CNT_W-1:0] elapsed;
    logic past_valid_q;

    assign elapsed = cnt + CNT_W'(1);

    always_comb begin
        st_d = st_q;
        cnt_clr = 1'b0;
        cnt_en = 1'b0;
        unique case (st_q.phase)
            PH_DELAY: begin
                cnt_en = 1'b1;
                if (cnt == WAIT_LAST) begin
                    st_d.phase = PH_TIMING;
                    st_d.light = 1'b1;
                    cnt_clr = 1'b1;
                end
            end
            PH_TIMING: begin
                cnt_en = 1'b1;
                if (button) begin
                    st_d.phase = PH_HOLD;
                    st_d.light = 1'b0;
                    st_d.rtime = TIME_W'(elapsed);
                    cnt_clr = 1'b1;
                end else if (elapsed == LIMIT_CNT) begin
                    st_d.phase = PH_HOLD;
                    st_d.light = 1'b0;
                    st_d.slow = 1'b1;
                    st_d.rtime = LIMIT_VAL;
                    cnt_clr = 1'b1;
                end
            end
            PH_HOLD: begin
                st_d = st_q;
            end
            default: begin
                st_d.phase = PH_DELAY;
                cnt_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_DELAY;
            st_q.light <= 1'b0;
            st_q.slow <= 1'b0;
            st_q.rtime <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        past_valid_q <= 1'b1;
    end

    assign light = st_q.light;
    assign slow = st_q.slow;
    assign rtime = st_q.rtime;

    // R1: reset clears every output on the following edge
    a_r1_reset_clears: assert property (@(posedge clk)
        (past_valid_q && $past(rst)) |-> (!st_q.light && !st_q.slow && st_q.rtime == '0));

    // R2: the light can only come on after the counter reached the final delay cycle
    a_r2_light_after_wait: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_DELAY && st_d.light) |-> (cnt == WAIT_LAST));

    // R4: a captured result always comes with the light off
    a_r4_light_off_done: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_HOLD) |-> !st_q.light);

    // R5: the slow flag always reports the limit value
    a_r5_slow_limit: assert property (@(posedge clk) disable iff (rst)
        st_q.slow |-> (st_q.rtime == LIMIT_VAL));

    // R8: results stay frozen while holding
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_HOLD) |=> ($stable(st_q.rtime) && $stable(st_q.slow)));

    // R9: nothing is reported while the light is on
    a_r9_quiet_while_lit: assert property (@(posedge clk) disable iff (rst)
        st_q.light |-> (st_q.rtime == '0 && !st_q.slow));

    // R3: a measured time never exceeds the limit
    a_r3_time_bounded: assert property (@(posedge clk) disable iff (rst)
        (st_q.rtime <= LIMIT_VAL));

endmodule

// File: rtl/reaction_timer.sv
module reaction_timer #(
    parameter int WAIT_CYCLES = 10000,
    parameter int LIMIT_MS = 2000,
    parameter int TIME_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              button,
    output logic              light_en,
    output logic [TIME_W-1:0] react_ms,
    output logic              too_slow
);

    localparam int SPAN = (WAIT_CYCLES > LIMIT_MS) ? WAIT_CYCLES : LIMIT_MS;
    localparam int CNT_W = $clog2(SPAN + 1);

    logic [CNT_W-1:0] cnt;
    logic cnt_clr;
    logic cnt_en;

    rt_cycle_counter #(
        .WIDTH(CNT_W)
    ) u_counter (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .en   (cnt_en),
        .count(cnt)
    );

    rt_phase_ctrl #(
        .CNT_W      (CNT_W),
        .TIME_W     (TIME_W),
        .WAIT_CYCLES(WAIT_CYCLES),
        .LIMIT_MS   (LIMIT_MS)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .button (button),
        .cnt    (cnt),
        .cnt_clr(cnt_clr),
        .cnt_en (cnt_en),
        .light  (light_en),
        .slow   (too_slow),
        .rtime  (react_ms)
    );

    // R3: the counter never runs past the longest window
    a_r3_count_in_span: assert property (@(posedge clk) disable iff (rst)
        (cnt <= CNT_W'(SPAN)));

endmodule

// File: tb/reaction_timer_test.sv
module reaction_timer_test;

    localparam int WAIT_CYCLES = 10000;
    localparam int LIMIT_MS = 2000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic button = 1'b0;
    logic light_en;
    logic [11:0] react_ms;
    logic too_slow;

    int checks = 0;
    int fails = 0;
    int exp_time_q[$];
    bit exp_slow_q[$];
    string exp_tag_q[$];
    logic prev_light = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    reaction_timer uut (
        .clk     (clk),
        .rst     (rst),
        .button  (button),
        .light_en(light_en),
        .react_ms(react_ms),
        .too_slow(too_slow)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: a falling light marks a captured result
    always @(negedge clk) begin
        if (!rst && prev_light && !light_en) begin
            if (exp_time_q.size() == 0) begin
                check("R3 unexpected capture", 1, 0);
            end else begin
                string tag;
                int et;
                bit es;
                tag = exp_tag_q.pop_front();
                et = exp_time_q.pop_front();
                es = exp_slow_q.pop_front();
                check({tag, " react_ms"}, int'(react_ms), et);
                check({tag, " too_slow"}, int'(too_slow), int'(es));
            end
        end
        prev_light = light_en;
    end

    task automatic trial(input int n, input bit hold_in_wait, input string tag);
        @(negedge clk);
        rst = 1'b1;
        button = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 light after reset", int'(light_en), 0);
        check("R1 react_ms after reset", int'(react_ms), 0);
        check("R1 too_slow after reset", int'(too_slow), 0);
        rst = 1'b0;
        button = hold_in_wait;
        repeat (WAIT_CYCLES - 1) @(negedge clk);
        check("R2 light before delay end", int'(light_en), 0);
        if (hold_in_wait) begin
            check("R7 react_ms during wait press", int'(react_ms), 0);
            check("R7 too_slow during wait press", int'(too_slow), 0);
        end
        button = 1'b0;
        @(negedge clk);
        check(hold_in_wait ? "R7 light at delay end" : "R2 light at delay end", int'(light_en), 1);
        check("R9 react_ms while lit", int'(react_ms), 0);
        if (n > 0) begin
            exp_tag_q.push_back(tag);
            exp_time_q.push_back(n);
            exp_slow_q.push_back(1'b0);
            repeat (n - 1) @(negedge clk);
            button = 1'b1;
            @(negedge clk);
            button = 1'b0;
        end else begin
            exp_tag_q.push_back(tag);
            exp_time_q.push_back(LIMIT_MS);
            exp_slow_q.push_back(1'b1);
            repeat (LIMIT_MS - 1) @(negedge clk);
            check("R9 too_slow one edge before limit", int'(too_slow), 0);
            @(negedge clk);
        end
        check("R4 light off at capture", int'(light_en), 0);
        // R8: later button activity must not disturb the result
        for (int i = 0; i < 6; i++) begin
            button = i[0];
            @(negedge clk);
        end
        button = 1'b0;
        check("R8 held react_ms", int'(react_ms), (n > 0) ? n : LIMIT_MS);
        check("R8 held too_slow", int'(too_slow), (n > 0) ? 0 : 1);
        check("R8 light stays off", int'(light_en), 0);
    endtask

    initial begin
        trial(1, 1'b0, "R3 press first edge");
        trial(337, 1'b0, "R3 press mid window");
        trial(LIMIT_MS, 1'b0, "R6 press at limit");
        trial(0, 1'b0, "R5 timeout");
        trial(1999, 1'b1, "R7 press after held wait");
        check("R3 all results seen", exp_time_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule